// File: doc/BRIEF.md
# Serial Slot-Select Write Sequencer

This block is the host-side engine that loads a slot-select word into the slot-0 register of a module backplane over a three-wire serial path. A single start pulse hands it a 16-bit word. The block pulls the active-low frame strobe down and waits a lead gap. It then shifts the word out most significant bit first. For each bit it drives the serial clock low and then high, and the rising edge is the sampling edge. After a trailing gap it raises the strobe, and that rising edge commits the new selection on the backplane.

All spacing is counted in system clock cycles. At 50 MHz the lead gap of 4 cycles gives at least 75 ns from the strobe falling to the first rising clock edge. The trailing gap of 13 cycles gives at least 250 ns from the last rising clock edge to the strobe rising. The bit time is set by the low-phase and high-phase lengths. Busy covers the whole transfer. A one-cycle done pulse follows once the strobe is high again.

Top module: `slot_select_writer`

## Requirements
- R1: After reset and whenever busy is low, the outputs are strobe_n=1, sclk=1, sdata=0 and done=0.
- R2: A start sampled high while idle latches the word, and on the next cycle strobe_n goes low and busy goes high. Busy stays high through the done cycle and drops on the cycle after it.
- R3: strobe_n stays low with sclk high for LEAD_CYC cycles (default 4) before the first falling edge of sclk. The first rising edge therefore comes LEAD_CYC+LOW_CYC cycles after the strobe falls. sclk is low only while strobe_n is low.
- R4: The word is sent most significant bit first. Each bit is on sdata from the cycle before sclk falls until the first high cycle after sclk rises. The next bit replaces it in the second high cycle, so sdata never changes in a cycle where sclk rises or falls. HIGH_CYC must be at least 2.
- R5: Each bit has LOW_CYC cycles of sclk low followed by HIGH_CYC cycles of sclk high, both at least 2. A transfer has exactly WORD_W rising edges.
- R6: After the last rising edge, sclk stays high and sdata holds the least significant bit. strobe_n stays low for HIGH_CYC+TRAIL_CYC cycles in total (TRAIL_CYC defaults to 13) and then rises.
- R7: The cycle after strobe_n rises is a release cycle with busy high and done low. On the following cycle done is high for exactly one cycle, and then the block is idle.
- R8: A start that arrives while busy is high is ignored and does not change the transfer in progress.
- R9: sdata is 0 in every cycle where strobe_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send `word`; accepted only while idle |
| word | input | WORD_W | Slot-select word to transmit |
| strobe_n | output | 1 | Active-low frame strobe to the slot-0 register |
| sclk | output | 1 | Serial clock; rising edge samples the data line |
| sdata | output | 1 | Serial data line, most significant bit first |
| busy | output | 1 | High from the first strobe-low cycle through done |
| done | output | 1 | One-cycle pulse that ends a transfer |

## Verification
The words sent are all zeros, all ones, 16'hA5C3, 16'h8001 and 16'h0001. Alternating and edge-only bit patterns show whether the bit order is reversed or shifted by one, and whether a bit changes at the wrong cycle of its high phase. Comparing all-zero and all-one words shows that sdata really follows the word and is not stuck at one value. A start raised mid-transfer shows whether requests are ignored while busy. Holding start high across two transfers shows that a new transfer begins only on the cycle after done, never during the release or done cycle.

// File: rtl/slot_select_writer.sv
module slot_select_writer #(
  parameter int WORD_W    = 16,
  parameter int LEAD_CYC  = 4,
  parameter int LOW_CYC   = 2,
  parameter int HIGH_CYC  = 2,
  parameter int TRAIL_CYC = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              strobe_n,
  output logic              sclk,
  output logic              sdata,
  output logic              busy,
  output logic              done
);
  localparam int M1   = (LEAD_CYC > LOW_CYC) ? LEAD_CYC : LOW_CYC;
  localparam int M2   = (HIGH_CYC > TRAIL_CYC) ? HIGH_CYC : TRAIL_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH, S_TRAIL, S_REL, S_DONE} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [WORD_W-1:0] sh;

  wire last_bit = (bitn == BW'(WORD_W - 1));
  wire cnt_zero = (cnt == '0);
  wire framed   = (st == S_LEAD) || (st == S_LOW) || (st == S_HIGH) || (st == S_TRAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          sh   <= word;
          bitn <= '0;
          cnt  <= CW'(LEAD_CYC - 1);
          st   <= S_LEAD;
        end
        S_LEAD: if (cnt_zero) begin
          cnt <= CW'(LOW_CYC - 1);
          st  <= S_LOW;
        end else cnt <= cnt - 1'b1;
        S_LOW: if (cnt_zero) begin
          cnt <= CW'(HIGH_CYC - 1);
          st  <= S_HIGH;
        end else cnt <= cnt - 1'b1;
        S_HIGH: begin
          if (cnt == CW'(HIGH_CYC - 1) && !last_bit) sh <= sh << 1;
          if (cnt_zero) begin
            if (last_bit) begin
              cnt <= CW'(TRAIL_CYC - 1);
              st  <= S_TRAIL;
            end else begin
              bitn <= bitn + 1'b1;
              cnt  <= CW'(LOW_CYC - 1);
              st   <= S_LOW;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_TRAIL: if (cnt_zero) st <= S_REL;
                 else cnt <= cnt - 1'b1;
        S_REL:   st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign strobe_n = !framed;
  assign sclk     = (st != S_LOW);
  assign sdata    = framed & sh[WORD_W-1];
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (strobe_n && sclk && !sdata && !done));
  p_busy_ends_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_sclk_low_framed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> !strobe_n);
  p_data_stable_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata));
  p_data_stable_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdata));
  p_strobe_rise_sclk_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n) |-> (sclk && $past(sclk)));
  p_done_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (strobe_n && $past(strobe_n) && $past(busy)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_no_data_unframed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n |-> !sdata);
endmodule

// File: tb/sim_slot_select_writer.sv
module sim_slot_select_writer;
  localparam int PERIOD = 20;
  localparam int WW = 16, LEAD = 4, LOWC = 2, HIGHC = 2, TRAIL = 13;
  localparam logic [4:0] IDLE_V = 5'b11000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [WW-1:0] word = '0;
  logic strobe_n, sclk, sdata, busy, done;

  int vectors = 0, miscompares = 0;
  logic [4:0] exp_q[$];

  always #(PERIOD/2) clk = ~clk;

  slot_select_writer #(.WORD_W(WW), .LEAD_CYC(LEAD), .LOW_CYC(LOWC),
                       .HIGH_CYC(HIGHC), .TRAIL_CYC(TRAIL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .word(word),
    .strobe_n(strobe_n), .sclk(sclk), .sdata(sdata), .busy(busy), .done(done));

  // expectation bits: {strobe_n, sclk, sdata, busy, done}
  task automatic push_frame(input logic [WW-1:0] w);
    for (int k = 0; k < LEAD; k++) exp_q.push_back({1'b0, 1'b1, w[WW-1], 2'b10});
    for (int i = WW-1; i >= 0; i--) begin
      for (int k = 0; k < LOWC; k++) exp_q.push_back({1'b0, 1'b0, w[i], 2'b10});
      exp_q.push_back({1'b0, 1'b1, w[i], 2'b10});
      for (int k = 1; k < HIGHC; k++)
        exp_q.push_back({1'b0, 1'b1, (i > 0) ? w[i-1] : w[0], 2'b10});
    end
    for (int k = 0; k < TRAIL; k++) exp_q.push_back({1'b0, 1'b1, w[0], 2'b10});
    exp_q.push_back(5'b11010);
    exp_q.push_back(5'b11011);
  endtask

  task automatic cmp(input string tag, input string nm, input logic a, input logic e);
    if (a !== e) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, nm, $time, a, e);
    end
  endtask

  task automatic tick(input logic go, input logic [WW-1:0] w);
    logic [4:0] e;
    @(negedge clk);
    e = (exp_q.size() != 0) ? exp_q.pop_front() : IDLE_V;
    vectors++;
    cmp("R2/R6", "strobe_n", strobe_n, e[4]);  // R1 R3 R6 R7
    cmp("R3/R5", "sclk", sclk, e[3]);          // R1 R5
    cmp("R4/R9", "sdata", sdata, e[2]);        // R1 R4 R9
    cmp("R2/R8", "busy", busy, e[1]);          // R8: ignored start keeps sequence
    cmp("R7", "done", done, e[0]);
    if (go && rst_n && !e[1]) push_frame(w);
    start = go;
    word  = w;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) tick(1'b0, '0);
    tick(1'b0, '0);
  endtask

  initial begin
    #(PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) tick(1'b0, '0);
    rst_n = 1'b1;
    tick(1'b0, '0);
    tick(1'b0, '0);
    // R2 R3 R4 R5 R6 R7 R9 with several words
    tick(1'b1, 16'h0000); drain();
    tick(1'b1, 16'hFFFF); drain();
    tick(1'b1, 16'hA5C3); drain();
    tick(1'b1, 16'h8001); drain();
    // R8: start while busy is ignored
    tick(1'b1, 16'h0001);
    repeat (10) tick(1'b0, '0);
    tick(1'b1, 16'hFFFF);
    repeat (30) tick(1'b1, 16'h7777);
    drain();
    // start held high: next transfer only after done
    repeat (120) tick(1'b1, 16'h5A3C);
    drain();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule